// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Engine with Mode-Fault Detection

This block moves one byte at a time over a four-wire serial peripheral link and can act either as the clock-driving master or as a slave that follows an external clock. Software drives it through a small register bus with three locations. The control register (address 0) holds the mode and timing fields. The status register (address 1) is read-only and holds the completion, overrun and mode-fault flags. The data register (address 2) starts a transfer when written and returns the last received byte when read. A read strobe returns its data on `bus_rdata` one clock after the strobe.

Control bit layout: [7] interrupt enable, [6] engine enable, [5] divider bypass, [4] master select, [3] clock idle level, [2] capture phase, [1:0] rate code. Status bit layout: [7] transfer done, [6] overrun, [5] mode fault, others 0. In master mode the block makes the serial clock from the system clock. In slave mode it passes the external clock and the active-low select through a synchronizer, then detects the clock edges. The input pins are `sck_in`, `mosi_in`, `miso_in` and `ss_n`, and each driven pin has its own output-enable, so that a pad ring can tristate it.

Top module: `spi_mfault_core`

## Requirements
- R1: After reset, control bits [7:4] read as 0 and the status register reads 0x00. `sck_oe`, `mosi_oe`, `miso_oe` and `irq` are all low.
- R2: `irq` equals, one clock later, control bit 7 AND (status bit 7 OR bit 6 OR bit 5). It stays low while control bit 7 is 0, even with a flag set.
- R3: With control bits 6 and 4 both set, a low on `ss_n` (after the SYNC_STAGES-flop synchronizer) sets status bit 5. In the same clock it clears control bits 6 and 4 in hardware, which releases the pins. Status bit 5 clears when a status read is followed by a control write.
- R4: While control bit 6 is 0, no output-enable is asserted, and a write to the data register starts no transfer and sets no flag.
- R5: In master mode, each SCK half period lasts 2^(rate+1) system clocks when control bit 5 is 0, and 2^rate clocks when bit 5 is 1. This gives full periods of 4, 8, 16, 32 or 2, 4, 8, 16 clocks.
- R6: Control bit 5 has no effect in slave mode. A slave transfer gives the same result with either value.
- R7: An enabled master drives `sck_oe` and `mosi_oe` high and `miso_oe` low. An enabled slave drives only `miso_oe`, and only while `ss_n` is low.
- R8: Control bit 3 sets the level of `sck_out` while a master is idle (0 = low, 1 = high).
- R9: Bits travel MSB first. With control bit 2 = 0, data is captured on the 1st, 3rd and later odd SCK transitions. With bit 2 = 1, it is captured on the 2nd, 4th and later even transitions. The master sends on `mosi_out` and receives on `miso_in`; the slave sends on `miso_out` and receives on `mosi_in`.
- R10: Status bit 7 sets at the eighth capture, and the received byte is then readable at address 2. Bit 7 clears when a status read that saw it set is followed by a read or write of address 2.
- R11: If a byte completes while status bit 7 is still set, status bit 6 sets and the receive buffer keeps the earlier byte. Bit 6 clears when a status read is followed by a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after `bus_rd` |
| irq | output | 1 | Combined interrupt request |
| ss_n | input | 1 | Active-low slave select / fault sense |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Output enable for `sck_out` |
| mosi_in | input | 1 | Serial data into the slave |
| mosi_out | output | 1 | Serial data out of the master |
| mosi_oe | output | 1 | Output enable for `mosi_out` |
| miso_in | input | 1 | Serial data into the master |
| miso_out | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Output enable for `miso_out` |

## Verification
A wrong edge counter or phase bit shows up within one byte: the captured MOSI byte from the master, or the received byte read back at address 2, comes out shifted or bit-reversed. A slip in the divider shows directly as a wrong spacing between `sck_out` transitions, which the bench measures in clocks. A broken flag sequence appears at the status register and on `irq` within two clocks of the event. A missing hardware clear on mode fault leaves `sck_oe` high a few clocks after `ss_n` falls.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int DATA_W = 8;
  localparam int RATE_W = 2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  localparam int ST_DONE  = 7;
  localparam int ST_OVR   = 6;
  localparam int ST_FAULT = 5;

  typedef struct packed {
    logic              irq_en;
    logic              enable;
    logic              div_bypass;
    logic              master;
    logic              cpol;
    logic              cpha;
    logic [RATE_W-1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen #(
  parameter int RATE_W = 2,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  input  logic              div2_on,
  output logic              tick
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [RATE_W:0]   shamt;

  always_comb begin
    shamt = {1'b0, rate} + {{RATE_W{1'b0}}, div2_on};
    limit = (CNT_W'(1) << shamt) - CNT_W'(1);
    tick  = run && (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         edge_stb,
  input  logic         cpha,
  input  logic         rx_in,
  output logic         out_bit,
  output logic         done,
  output logic [W-1:0] rx_byte,
  output logic         last_edge,
  output logic         idle
);
  localparam int EC_W = $clog2(2 * W);

  logic [EC_W-1:0] ecnt;
  logic [W-1:0]    sh;
  logic            cap;
  logic            shf;

  always_comb begin
    cap       = edge_stb && (ecnt[0] == cpha);
    shf       = edge_stb && (ecnt[0] != cpha);
    rx_byte   = {sh[W-2:0], rx_in};
    done      = cap && (ecnt[EC_W-1:1] == (EC_W-1)'(W - 1));
    last_edge = edge_stb && (ecnt == EC_W'(2 * W - 1));
    idle      = (ecnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt    <= '0;
      sh      <= '0;
      out_bit <= 1'b0;
    end else if (load) begin
      sh      <= load_val;
      out_bit <= load_val[W-1];
      ecnt    <= '0;
    end else if (clr) begin
      ecnt <= '0;
    end else if (edge_stb) begin
      ecnt <= last_edge ? '0 : ecnt + EC_W'(1);
      if (cap) sh      <= rx_byte;
      if (shf) out_bit <= sh[W-1];
    end
  end
endmodule

// File: rtl/spi_mf_regs.sv
module spi_mf_regs
  import spi_mf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fault,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output ctrl_t             ctrl,
  output logic              data_wr,
  output logic              irq,
  output logic              spif,
  output logic              ovr,
  output logic              modf,
  output logic [DATA_W-1:0] rx_buf
);
  logic [3:0] ctrl_hi;
  logic [3:0] ctrl_lo;
  logic       wr_ctrl, rd_stat, rd_data, data_acc;
  logic       arm_spif, arm_ovr, arm_modf;
  logic       clr_spif, clr_ovr, clr_modf, spif_held;
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    ctrl      = {ctrl_hi, ctrl_lo};
    wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
    data_wr   = bus_wr && (bus_addr == REG_DATA);
    rd_stat   = bus_rd && (bus_addr == REG_STAT);
    rd_data   = bus_rd && (bus_addr == REG_DATA);
    data_acc  = data_wr || rd_data;
    clr_spif  = data_acc && arm_spif;
    clr_ovr   = rd_data && arm_ovr;
    clr_modf  = wr_ctrl && arm_modf;
    spif_held = spif && !clr_spif;
    stat_word = '0;
    stat_word[ST_DONE]  = spif;
    stat_word[ST_OVR]   = ovr;
    stat_word[ST_FAULT] = modf;
  end

  // timing fields carry no reset value
  always_ff @(posedge clk) begin
    if (wr_ctrl) ctrl_lo <= bus_wdata[3:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_hi <= '0;
    end else begin
      if (wr_ctrl) ctrl_hi <= bus_wdata[7:4];
      if (fault) begin
        ctrl_hi[2] <= 1'b0;
        ctrl_hi[0] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_spif <= 1'b0;
      arm_ovr  <= 1'b0;
      arm_modf <= 1'b0;
    end else if (rd_stat) begin
      arm_spif <= spif;
      arm_ovr  <= ovr;
      arm_modf <= modf;
    end else begin
      if (data_acc) arm_spif <= 1'b0;
      if (rd_data)  arm_ovr  <= 1'b0;
      if (wr_ctrl)  arm_modf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spif   <= 1'b0;
      ovr    <= 1'b0;
      modf   <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (done)          spif <= 1'b1;
      else if (clr_spif) spif <= 1'b0;
      if (done && spif_held) ovr <= 1'b1;
      else if (clr_ovr)      ovr <= 1'b0;
      if (done && !spif_held) rx_buf <= rx_byte;
      if (fault)         modf <= 1'b1;
      else if (clr_modf) modf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ctrl.irq_en && (spif || ovr || modf);
      if (bus_rd) begin
        case (bus_addr)
          REG_CTRL: bus_rdata <= ctrl;
          REG_STAT: bus_rdata <= stat_word;
          REG_DATA: bus_rdata <= rx_buf;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_mfault_core.sv
module spi_mfault_core
  import spi_mf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       ss_n,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       mosi_in,
  output logic       mosi_out,
  output logic       mosi_oe,
  input  logic       miso_in,
  output logic       miso_out,
  output logic       miso_oe
);
  localparam int CNT_W = (1 << RATE_W) + 1;

  ctrl_t ctrl;
  logic  data_wr, spif, ovr, modf, done, last_edge, sh_idle, out_bit, tick;
  logic [DATA_W-1:0] rx_byte, rx_buf;
  logic [SYNC_STAGES-1:0] ss_sync, sck_sync;
  logic  sck_prev, busy, sck_r;
  logic  m_en, s_en, ss_lo, fault, s_sel, sck_s, s_edge, m_edge;
  logic  edge_stb, rx_in, start, load, clr;

  always_comb begin
    m_en     = ctrl.enable && ctrl.master;
    s_en     = ctrl.enable && !ctrl.master;
    ss_lo    = !ss_sync[SYNC_STAGES-1];
    sck_s    = sck_sync[SYNC_STAGES-1];
    fault    = m_en && ss_lo;
    s_sel    = s_en && ss_lo;
    s_edge   = s_sel && (sck_s != sck_prev);
    m_edge   = m_en && busy && tick;
    edge_stb = m_en ? m_edge : s_edge;
    rx_in    = ctrl.master ? miso_in : mosi_in;
    start    = data_wr && m_en && !busy && !fault;
    load     = start || (data_wr && s_en && sh_idle);
    clr      = !ctrl.enable || (s_en && !ss_lo) || (busy && !m_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_sync  <= '1;
      sck_sync <= '0;
      sck_prev <= 1'b0;
    end else begin
      ss_sync  <= (ss_sync << 1) | SYNC_STAGES'(ss_n);
      sck_sync <= (sck_sync << 1) | SYNC_STAGES'(sck_in);
      sck_prev <= sck_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sck_r <= 1'b0;
    end else begin
      if (!m_en || fault)          busy <= 1'b0;
      else if (start)              busy <= 1'b1;
      else if (m_edge && last_edge) busy <= 1'b0;
      if (m_edge)     sck_r <= ~sck_r;
      else if (!busy) sck_r <= ctrl.cpol;
    end
  end

  spi_mf_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault(fault), .done(done),
    .rx_byte(rx_byte), .ctrl(ctrl), .data_wr(data_wr), .irq(irq),
    .spif(spif), .ovr(ovr), .modf(modf), .rx_buf(rx_buf)
  );

  spi_mf_clkgen #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_clk (
    .clk(clk), .rst(rst), .run(m_en && busy), .rate(ctrl.rate),
    .div2_on(!ctrl.div_bypass), .tick(tick)
  );

  spi_mf_shifter #(.W(DATA_W)) u_sh (
    .clk(clk), .rst(rst), .load(load), .load_val(bus_wdata), .clr(clr),
    .edge_stb(edge_stb), .cpha(ctrl.cpha), .rx_in(rx_in), .out_bit(out_bit),
    .done(done), .rx_byte(rx_byte), .last_edge(last_edge), .idle(sh_idle)
  );

  always_comb begin
    sck_out  = sck_r;
    sck_oe   = m_en;
    mosi_out = out_bit;
    mosi_oe  = m_en;
    miso_out = out_bit;
    miso_oe  = s_sel;
  end
endmodule

// File: rtl/spi_mfault_chk.sv
module spi_mfault_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       irq_en,
  input logic       enable,
  input logic       master,
  input logic       cpol,
  input logic       busy,
  input logic       spif,
  input logic       ovr,
  input logic       modf,
  input logic       done,
  input logic [7:0] rx_buf,
  input logic       sck_out,
  input logic       sck_oe,
  input logic       mosi_oe,
  input logic       miso_oe
);
  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    irq == $past(irq_en && (spif || ovr || modf))); // R2

  AST_FAULT_DROPS_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(modf) |-> (!enable && !master)); // R3

  AST_FAULT_RELEASES_PINS: assert property (@(posedge clk) disable iff (rst)
    $rose(modf) |-> (!sck_oe && !mosi_oe)); // R3

  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!sck_oe && !mosi_oe && !miso_oe)); // R4

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (enable && master && !busy && $past(!busy) && $past(enable && master) && $stable(cpol))
      |-> (sck_out == cpol)); // R8

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |=> spif); // R10

  AST_OVERRUN_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $stable(rx_buf)); // R11
endmodule

bind spi_mfault_core spi_mfault_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_en(ctrl.irq_en), .enable(ctrl.enable),
  .master(ctrl.master), .cpol(ctrl.cpol), .busy(busy), .spif(spif), .ovr(ovr),
  .modf(modf), .done(done), .rx_buf(rx_buf), .sck_out(sck_out), .sck_oe(sck_oe),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe)
);

// File: tb/sim_spi_mfault_core.sv
module sim_spi_mfault_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
  logic       ss_n = 1'b1, sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spi_mfault_core u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .ss_n(ss_n),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .mosi_in(mosi_in),
    .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_in(miso_in),
    .miso_out(miso_out), .miso_oe(miso_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] cbyte(input logic ie, en, bp, ms, pol, pha,
                                       input logic [1:0] rate);
    return {ie, en, bp, ms, pol, pha, rate};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one master byte with a bench peer on miso_in; returns MOSI byte and half period.
  task automatic run_master(input logic pol, pha, input logic [7:0] tx, peer,
                            output logic [7:0] got, output int half);
    int edges = 0, cyc = 0, t2 = 0, pbit;
    logic prev = pol;
    got = 8'h00; half = 0;
    miso_in = pha ? 1'b0 : peer[7];
    pbit = pha ? 7 : 6;
    bus_write(2'd2, tx);
    while (edges < 16 && cyc < 2000) begin
      if (sck_out !== prev) begin
        prev = sck_out;
        if (edges == 2) t2 = cyc;
        if (edges == 3) half = cyc - t2;
        if ((edges % 2) == int'(pha)) got = {got[6:0], mosi_out};
        else if (pbit >= 0) begin miso_in = peer[pbit]; pbit--; end
        edges++;
      end
      @(negedge clk); cyc++;
    end
    wait_clk(3);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(2'd0, d); check("R1 ctrl upper nibble", d & 8'hF0, 0);
    bus_read(2'd1, d); check("R1 status", d, 0);
    check("R1 output enables", {sck_oe, mosi_oe, miso_oe}, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    int changes = 0;
    logic prev;
    bus_write(2'd0, cbyte(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0));
    wait_clk(2);
    prev = sck_out;
    bus_write(2'd2, 8'h5A);
    for (int i = 0; i < 64; i++) begin
      if (sck_out !== prev) changes++;
      prev = sck_out;
      @(negedge clk);
    end
    check("R4 no enables while off", {sck_oe, mosi_oe, miso_oe}, 0);
    check("R4 no sck activity", changes, 0);
    bus_read(2'd1, d); check("R4 no flag while off", d, 0);
  endtask

  task automatic t_master(input logic pol, pha, bp, input logic [1:0] rate,
                          input logic [7:0] tx, peer);
    logic [7:0] got, d;
    int half;
    ss_n = 1'b1;
    bus_write(2'd0, cbyte(1'b0, 1'b1, bp, 1'b1, pol, pha, rate));
    wait_clk(3);
    check("R8 idle level before", sck_out, pol);
    check("R7 master enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    run_master(pol, pha, tx, peer, got, half);
    check("R5 half period", half, 1 << (int'(rate) + (bp ? 0 : 1)));
    check("R9 master MOSI byte", got, tx);
    check("R8 idle level after", sck_out, pol);
    bus_read(2'd1, d); check("R10 done flag", d, 8'h80);
    bus_read(2'd2, d); check("R9 master received byte", d, peer);
    bus_read(2'd1, d); check("R10 done flag cleared", d, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] got, d;
    int half;
    bus_write(2'd0, cbyte(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0));
    wait_clk(2);
    run_master(1'b0, 1'b0, 8'h11, 8'h3C, got, half);
    run_master(1'b0, 1'b0, 8'h22, 8'hA5, got, half);
    bus_read(2'd1, d); check("R11 overrun status", d, 8'hC0);
    bus_read(2'd2, d); check("R11 buffer keeps first byte", d, 8'h3C);
    bus_read(2'd1, d); check("R11 overrun cleared", d, 8'h00);
  endtask

  task automatic t_irq_gate();
    logic [7:0] got, d;
    int half;
    bus_write(2'd0, cbyte(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0));
    wait_clk(2);
    run_master(1'b1, 1'b1, 8'hC3, 8'h96, got, half);
    check("R2 irq masked", irq, 0);
    bus_write(2'd0, cbyte(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0));
    wait_clk(2);
    check("R2 irq raised", irq, 1);
    bus_read(2'd1, d);
    bus_read(2'd2, d);
    wait_clk(2);
    check("R2 irq drops with flag", irq, 0);
  endtask

  task automatic t_slave(input logic pol, pha, bp, input logic [7:0] rx_exp, dut_tx);
    logic [7:0] got = 8'h00, d;
    int pbit = pha ? 7 : 6;
    ss_n = 1'b1; sck_in = pol;
    mosi_in = pha ? 1'b0 : rx_exp[7];
    bus_write(2'd0, cbyte(1'b0, 1'b1, bp, 1'b0, pol, pha, 2'd3));
    bus_write(2'd2, dut_tx);
    wait_clk(4);
    check("R7 deselected slave quiet", {sck_oe, mosi_oe, miso_oe}, 0);
    ss_n = 1'b0;
    wait_clk(6);
    check("R7 selected slave drives miso only", {sck_oe, mosi_oe, miso_oe}, 3'b001);
    for (int e = 0; e < 16; e++) begin
      if ((e % 2) == int'(pha)) got = {got[6:0], miso_out};
      sck_in = ~sck_in;
      if ((e % 2) != int'(pha) && pbit >= 0) begin mosi_in = rx_exp[pbit]; pbit--; end
      wait_clk(8);
    end
    ss_n = 1'b1;
    wait_clk(6);
    check("R6 slave ignores divider bit, sck not driven", sck_oe, 0);
    check("R9 slave MISO byte", got, dut_tx);
    bus_read(2'd1, d); check("R10 slave done flag", d, 8'h80);
    bus_read(2'd2, d); check("R6 R9 slave received byte", d, rx_exp);
    bus_read(2'd1, d); check("R10 slave flag cleared", d, 8'h00);
  endtask

  task automatic t_fault();
    logic [7:0] d;
    ss_n = 1'b1;
    bus_write(2'd0, cbyte(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1));
    wait_clk(4);
    check("R3 master driving before fault", sck_oe, 1);
    ss_n = 1'b0;
    wait_clk(5);
    check("R3 pins released", {sck_oe, mosi_oe}, 0);
    bus_read(2'd0, d); check("R3 enable and master cleared", d & 8'hD0, 8'h80);
    bus_read(2'd1, d); check("R3 fault flag", d, 8'h20);
    check("R2 irq on fault", irq, 1);
    ss_n = 1'b1;
    bus_write(2'd0, cbyte(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1));
    wait_clk(3);
    bus_read(2'd1, d); check("R3 fault cleared", d, 8'h00);
    check("R2 irq clear", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_disabled();
    t_master(1'b0, 1'b0, 1'b1, 2'd0, 8'hA5, 8'h5C);
    t_master(1'b1, 1'b1, 1'b0, 2'd1, 8'h3E, 8'hC1);
    t_master(1'b1, 1'b0, 1'b0, 2'd3, 8'h81, 8'h7E);
    t_master(1'b0, 1'b1, 1'b1, 2'd2, 8'h69, 8'h0F);
    t_overrun();
    t_irq_gate();
    t_slave(1'b0, 1'b0, 1'b0, 8'hB2, 8'h4D);
    t_slave(1'b1, 1'b1, 1'b1, 8'h1E, 8'hE7);
    t_slave(1'b0, 1'b1, 1'b0, 8'h93, 8'h2C);
    t_fault();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule